// File: doc/BRIEF.md
# Chained Byte DMA Address and Count Engine

This block is the address and byte-count engine for one DMA channel that serves a byte-wide parallel port. It holds a current address and a current byte count. A second, shadow address and count are kept for the segment that follows. Software programs the engine through a small 32-bit register bus. A direction register selects which way bytes move. The engine then requests bytes one at a time from the port or FIFO side. Each acknowledged byte advances the address by one and lowers the count by one.

When the count steps from one to zero, the engine raises a terminal flag. If interrupts are enabled, it also raises its interrupt line. In unchained operation the engine then stops. In chained operation it loads the shadow address and count into the current registers and keeps going, so a list of buffers can be walked without a gap. The shadow registers sit at the same bus offsets as the current ones. A bank-select bit in the control register chooses which set those offsets reach.

The sequencer has three states. ST_IDLE waits for the run bit and a nonzero count. ST_XFER requests bytes. ST_HALT holds after an unchained terminal count until software clears the flag. The transitions are as follows:
- T_START (ST_IDLE to ST_XFER): the run bit is set and the count is nonzero.
- T_STOP (ST_XFER to ST_IDLE): the run bit is clear or the count is zero.
- T_ABORT (ST_XFER to ST_IDLE): software ends an unchained transfer.
- T_RELOAD (ST_XFER to ST_XFER): chained terminal count with a nonzero shadow count.
- T_RELOAD_EMPTY (ST_XFER to ST_IDLE): chained terminal count with a zero shadow count.
- T_EXPIRE (ST_XFER to ST_HALT): unchained terminal count.
- T_CLEAR (ST_HALT to ST_IDLE): the flag has been cleared.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, byte_req and irq are low, byte_dir is 0, and every register reads zero.
- R2: While the run bit (control bit 0) is set and the current count is nonzero, byte_req is high. Each cycle with byte_req and byte_ack both high moves one byte: byte_addr rises by one and the count falls by one at the next edge.
- R3: When the count steps from 1 to 0, the terminal flag (control bit 9) is set. irq is high while the flag and the interrupt enable (control bit 4) are both set. Writing 0 to bit 9 clears the flag, and writing 1 leaves it unchanged.
- R4: In unchained mode, a terminal count stops the engine: byte_req drops and the run bit reads 0.
- R5: During an unchained transfer, a control write with bit 9 at 0 ends the transfer. The run bit clears, byte_req drops, and later acknowledges change neither the address nor the count.
- R6: Chained mode is active when both control bit 13 and control bit 24 are set. At terminal count, the shadow address and the shadow count are copied into the current registers and requesting continues. The shadow count keeps its value after the copy. If the copied count is zero, the engine goes idle.
- R7: Offset 2 is the address register and offset 3 is the count register. They reach the shadow registers while control bit 24 is set, and the current registers otherwise.
- R8: Bit 0 of the direction register at offset 1 drives byte_dir and reads back at control bit 8. Writes to control bit 8 have no effect.
- R9: A software write to the current address or count wins over a byte step or reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 direction, 2 address, 3 count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| byte_req | output | 1 | Request for one byte transfer |
| byte_ack | input | 1 | One byte moved this cycle |
| byte_addr | output | 32 | Current transfer address |
| byte_dir | output | 1 | Transfer direction |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives a buffer through its terminal count and checks where each byte lands. A design that stopped one byte early or late, or that kept requesting after an unchained expiry, would send a byte to an address the scoreboard does not expect.

It walks a chain of three segments without rewriting the shadow count. This catches a reload that clears or consumes the shadow count. It also catches a reload that fails to idle on a zero count.

It aborts an unchained transfer and then keeps acknowledging. A design that ignored the abort would keep moving bytes.

It collides a count write with a byte acknowledge. A design with the wrong priority would read back the decremented value instead of the written one.

// File: rtl/dce_pkg.sv
package dce_pkg;
    localparam int REG_DW = 32;

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_DIR  = 2'd1;
    localparam logic [1:0] OFS_ADDR = 2'd2;
    localparam logic [1:0] OFS_CNT  = 2'd3;

    localparam int BIT_RUN   = 0;
    localparam int BIT_IE    = 4;
    localparam int BIT_DIRM  = 8;
    localparam int BIT_FLAG  = 9;
    localparam int BIT_CHAIN = 13;
    localparam int BIT_BANK  = 24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_HALT = 2'd2
    } dce_state_e;
endpackage

// File: rtl/dce_regs.sv
module dce_regs
    import dce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              expire,
    input  logic              run_clr,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  cur_cnt,
    output logic              run,
    output logic              ie,
    output logic              flag,
    output logic              chained,
    output logic              dir,
    output logic [ADDR_W-1:0] next_addr,
    output logic [CNT_W-1:0]  next_cnt,
    output logic              wr_cur_addr,
    output logic              wr_cur_cnt,
    output logic              ctrl_wr_noflag
);
    logic chain_bit_q;
    logic bank_q;
    logic ctrl_wr, dir_wr, addr_wr, cnt_wr;

    assign ctrl_wr = reg_we && (reg_addr == OFS_CTRL);
    assign dir_wr  = reg_we && (reg_addr == OFS_DIR);
    assign addr_wr = reg_we && (reg_addr == OFS_ADDR);
    assign cnt_wr  = reg_we && (reg_addr == OFS_CNT);

    assign wr_cur_addr    = addr_wr && !bank_q;
    assign wr_cur_cnt     = cnt_wr  && !bank_q;
    assign ctrl_wr_noflag = ctrl_wr && !reg_wdata[BIT_FLAG];
    assign chained        = chain_bit_q && bank_q;

    // control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run         <= 1'b0;
            ie          <= 1'b0;
            chain_bit_q <= 1'b0;
            bank_q      <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ie          <= reg_wdata[BIT_IE];
                chain_bit_q <= reg_wdata[BIT_CHAIN];
                bank_q      <= reg_wdata[BIT_BANK];
            end
            if (run_clr) begin
                run <= 1'b0;
            end else if (ctrl_wr) begin
                run <= reg_wdata[BIT_RUN];
            end
        end
    end

    // terminal flag: hardware set wins, software may only clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (ctrl_wr && !reg_wdata[BIT_FLAG]) begin
            flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir <= 1'b0;
        end else if (dir_wr) begin
            dir <= reg_wdata[0];
        end
    end

    // shadow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_addr <= '0;
            next_cnt  <= '0;
        end else begin
            if (addr_wr && bank_q) next_addr <= reg_wdata[ADDR_W-1:0];
            if (cnt_wr  && bank_q) next_cnt  <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[BIT_RUN]   = run;
                reg_rdata[BIT_IE]    = ie;
                reg_rdata[BIT_DIRM]  = dir;
                reg_rdata[BIT_FLAG]  = flag;
                reg_rdata[BIT_CHAIN] = chain_bit_q;
                reg_rdata[BIT_BANK]  = bank_q;
            end
            OFS_DIR:  reg_rdata[0] = dir;
            OFS_ADDR: reg_rdata = bank_q ? REG_DW'(next_addr) : REG_DW'(cur_addr);
            OFS_CNT:  reg_rdata = bank_q ? REG_DW'(next_cnt)  : REG_DW'(cur_cnt);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dce_datapath.sv
module dce_datapath
    import dce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cur_addr,
    input  logic              wr_cur_cnt,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              step,
    input  logic              reload,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [CNT_W-1:0]  next_cnt,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              cnt_nz,
    output logic              cnt_one
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    assign cnt_nz  = (cur_cnt != '0);
    assign cnt_one = (cur_cnt == CNT_ONE);

    // priority: software write, then reload, then per-byte step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (wr_cur_addr) begin
            cur_addr <= reg_wdata[ADDR_W-1:0];
        end else if (reload) begin
            cur_addr <= next_addr;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cnt <= '0;
        end else if (wr_cur_cnt) begin
            cur_cnt <= reg_wdata[CNT_W-1:0];
        end else if (reload) begin
            cur_cnt <= next_cnt;
        end else if (step) begin
            cur_cnt <= cur_cnt - CNT_ONE;
        end
    end
endmodule

// File: rtl/dce_fsm.sv
module dce_fsm
    import dce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic chained,
    input  logic cnt_nz,
    input  logic cnt_one,
    input  logic next_nz,
    input  logic flag,
    input  logic ctrl_wr_noflag,
    input  logic byte_ack,
    output logic byte_req,
    output logic step,
    output logic expire,
    output logic reload,
    output logic run_clr
);
    dce_state_e state_q, state_d;
    logic abort;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run && cnt_nz) state_d = ST_XFER;             // T_START
            end
            ST_XFER: begin
                if (expire) begin
                    if (!chained)     state_d = ST_HALT;          // T_EXPIRE
                    else if (next_nz) state_d = ST_XFER;          // T_RELOAD
                    else              state_d = ST_IDLE;          // T_RELOAD_EMPTY
                end else if (abort) begin
                    state_d = ST_IDLE;                            // T_ABORT
                end else if (!run || !cnt_nz) begin
                    state_d = ST_IDLE;                            // T_STOP
                end
            end
            ST_HALT: begin
                if (!flag) state_d = ST_IDLE;                     // T_CLEAR
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        byte_req = (state_q == ST_XFER) && cnt_nz;
        step     = byte_req && byte_ack;
        expire   = step && cnt_one;
        reload   = expire && chained;
        abort    = (state_q == ST_XFER) && !chained && ctrl_wr_noflag;
        run_clr  = (expire && !chained) || abort;
    end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              byte_req,
    input  logic              byte_ack,
    output logic [ADDR_W-1:0] byte_addr,
    output logic              byte_dir,
    output logic              irq
);
    logic              run, ie, flag, chained;
    logic [ADDR_W-1:0] cur_addr, next_addr;
    logic [CNT_W-1:0]  cur_cnt, next_cnt;
    logic              wr_cur_addr, wr_cur_cnt, ctrl_wr_noflag;
    logic              step, expire, reload, run_clr;
    logic              cnt_nz, cnt_one;

    dce_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .expire(expire), .run_clr(run_clr),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt),
        .run(run), .ie(ie), .flag(flag), .chained(chained), .dir(byte_dir),
        .next_addr(next_addr), .next_cnt(next_cnt),
        .wr_cur_addr(wr_cur_addr), .wr_cur_cnt(wr_cur_cnt),
        .ctrl_wr_noflag(ctrl_wr_noflag)
    );

    dce_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_path (
        .clk(clk), .rst_n(rst_n),
        .wr_cur_addr(wr_cur_addr), .wr_cur_cnt(wr_cur_cnt), .reg_wdata(reg_wdata),
        .step(step), .reload(reload),
        .next_addr(next_addr), .next_cnt(next_cnt),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt),
        .cnt_nz(cnt_nz), .cnt_one(cnt_one)
    );

    dce_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .run(run), .chained(chained), .cnt_nz(cnt_nz), .cnt_one(cnt_one),
        .next_nz(next_cnt != '0), .flag(flag), .ctrl_wr_noflag(ctrl_wr_noflag),
        .byte_ack(byte_ack), .byte_req(byte_req),
        .step(step), .expire(expire), .reload(reload), .run_clr(run_clr)
    );

    assign byte_addr = cur_addr;
    assign irq       = flag && ie;
endmodule

// File: rtl/dce_checks.sv
module dce_checks #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_req,
    input logic              byte_ack,
    input logic              irq,
    input logic [ADDR_W-1:0] byte_addr,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic [ADDR_W-1:0] next_addr,
    input logic              flag,
    input logic              chained,
    input logic              wr_cur_addr,
    input logic              wr_cur_cnt,
    input logic [31:0]       reg_wdata
);
    localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);
    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

    logic moved, last;
    assign moved = byte_req && byte_ack;
    assign last  = moved && (cur_cnt == C_ONE);

    assert_req_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> (cur_cnt != '0));
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (moved && !last && !wr_cur_addr) |=> (byte_addr == $past(byte_addr) + A_ONE));
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (moved && !last && !wr_cur_cnt) |=> (cur_cnt == $past(cur_cnt) - C_ONE));
    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> flag);
    assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
    assert_unchained_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !chained) |=> !byte_req);
    assert_reload_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last && chained && !wr_cur_addr) |=> (byte_addr == $past(next_addr)));
    assert_sw_cnt_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cur_cnt |=> (cur_cnt == $past(reg_wdata[CNT_W-1:0])));
endmodule

bind dma_chain_engine dce_checks #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .byte_req(byte_req), .byte_ack(byte_ack), .irq(irq),
    .byte_addr(byte_addr), .cur_cnt(cur_cnt), .next_addr(next_addr), .flag(flag),
    .chained(chained), .wr_cur_addr(wr_cur_addr), .wr_cur_cnt(wr_cur_cnt),
    .reg_wdata(reg_wdata)
);

// File: tb/dma_chain_engine_test.sv
module dma_chain_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        byte_req;
    logic        byte_ack = 1'b0;
    logic [31:0] byte_addr;
    logic        byte_dir;
    logic        irq;

    int n_checks = 0;
    int n_err = 0;
    logic [31:0] exp_q[$];

    dma_chain_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .byte_req(byte_req),
        .byte_ack(byte_ack), .byte_addr(byte_addr), .byte_dir(byte_dir), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    task automatic wr(input logic [1:0] off, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = off; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] off, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = off;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    // driver: push the addresses expected on the port, then acknowledge n bytes
    task automatic run_bytes(input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(base + i);
        while (!byte_req) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_ack = 1'b1;
        end
        @(negedge clk);
        byte_ack = 1'b0;
        #1;
    endtask

    // monitor: every accepted byte must match the next expected address
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && byte_req && byte_ack) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected byte", byte_addr, 32'hFFFF_FFFF);
                end else begin
                    check("R2 byte address", byte_addr, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset
        check("R1 req", {31'b0, byte_req}, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 dir", {31'b0, byte_dir}, 0);
        rd_check("R1 ctrl", 2'd0, 0);
        rd_check("R1 addr", 2'd2, 0);
        rd_check("R1 cnt", 2'd3, 0);

        // R8 direction mirror, read-only in control
        wr(2'd0, 32'h100);
        rd_check("R8 mirror write ignored", 2'd0, 32'h0);
        wr(2'd1, 32'h1);
        #1;
        check("R8 byte_dir", {31'b0, byte_dir}, 1);
        rd_check("R8 dir reg", 2'd1, 32'h1);
        rd_check("R8 mirror", 2'd0, 32'h100);

        // R2 R3 R4 unchained run of three bytes with interrupt enabled
        wr(2'd2, 32'h100);
        wr(2'd3, 32'd3);
        wr(2'd0, 32'h011);
        run_bytes(32'h100, 3);
        check("R3 irq at expiry", {31'b0, irq}, 1);
        check("R4 req dropped", {31'b0, byte_req}, 0);
        rd_check("R4 run cleared flag set", 2'd0, 32'h310);
        rd_check("R2 count zero", 2'd3, 0);
        rd_check("R2 address advanced", 2'd2, 32'h103);
        wr(2'd0, 32'h210);
        #1;
        check("R3 write one keeps flag", {31'b0, irq}, 1);
        wr(2'd0, 32'h010);
        #1;
        check("R3 write zero clears", {31'b0, irq}, 0);

        // R5 abort an unchained transfer, then acknowledges are ignored
        wr(2'd2, 32'h200);
        wr(2'd3, 32'd10);
        wr(2'd0, 32'h001);
        run_bytes(32'h200, 2);
        wr(2'd0, 32'h001);
        #1;
        check("R5 req after abort", {31'b0, byte_req}, 0);
        rd_check("R5 run cleared", 2'd0, 32'h100);
        @(negedge clk); byte_ack = 1'b1;
        repeat (3) @(negedge clk);
        byte_ack = 1'b0;
        rd_check("R5 count held", 2'd3, 32'd8);
        rd_check("R5 address held", 2'd2, 32'h202);

        // R3 interrupt gated by enable
        wr(2'd3, 32'd1);
        wr(2'd0, 32'h001);
        run_bytes(32'h202, 1);
        check("R3 irq masked", {31'b0, irq}, 0);
        rd_check("R3 flag without enable", 2'd0, 32'h300);
        wr(2'd0, 32'h210);
        #1;
        check("R3 irq on enable", {31'b0, irq}, 1);
        wr(2'd0, 32'h000);

        // R7 banking
        wr(2'd2, 32'h300);
        wr(2'd3, 32'd2);
        wr(2'd0, 32'h0100_0000);
        wr(2'd2, 32'h400);
        wr(2'd3, 32'd3);
        rd_check("R7 shadow addr", 2'd2, 32'h400);
        rd_check("R7 shadow cnt", 2'd3, 32'd3);
        wr(2'd0, 32'h0);
        rd_check("R7 current addr", 2'd2, 32'h300);
        rd_check("R7 current cnt", 2'd3, 32'd2);

        // R6 chained walk of three segments
        wr(2'd0, 32'h0100_2011);
        run_bytes(32'h300, 2);
        check("R6 irq at first reload", {31'b0, irq}, 1);
        check("R6 continues after reload", {31'b0, byte_req}, 1);
        check("R6 address reloaded", byte_addr, 32'h400);
        wr(2'd0, 32'h0100_2011);
        #1;
        check("R6 flag clear keeps running", {31'b0, byte_req}, 1);
        check("R6 irq cleared", {31'b0, irq}, 0);
        wr(2'd2, 32'h500);
        run_bytes(32'h400, 3);
        check("R6 second reload addr", byte_addr, 32'h500);
        rd_check("R6 shadow count kept", 2'd3, 32'd3);
        wr(2'd0, 32'h0100_2011);
        wr(2'd3, 32'd0);
        run_bytes(32'h500, 3);
        check("R6 zero reload idles", {31'b0, byte_req}, 0);
        check("R6 last reload addr", byte_addr, 32'h500);
        wr(2'd0, 32'h0);
        rd_check("R6 current count zero", 2'd3, 0);

        // R9 software count write collides with a byte acknowledge
        wr(2'd2, 32'h600);
        wr(2'd3, 32'd5);
        wr(2'd0, 32'h001);
        exp_q.push_back(32'h600);
        while (!byte_req) @(negedge clk);
        @(negedge clk);
        byte_ack = 1'b1; reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 32'd7;
        @(negedge clk);
        byte_ack = 1'b0; reg_we = 1'b0;
        rd_check("R9 write wins", 2'd3, 32'd7);
        rd_check("R9 address stepped", 2'd2, 32'h601);
        wr(2'd0, 32'h0);
        #1;
        check("R9 stopped", {31'b0, byte_req}, 0);

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule